// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block copies a run of aligned 32-bit words from one memory region to another. Software programs a source address, a destination address, a byte count and a control word through a small 32-bit register port, then sets the launch bit. The engine issues word reads on a request/response read port, then writes each returned word out on a write port. Both ports use valid/ready handshakes. The launch bit reads back as a busy indication until the run ends.

Two options shape the address stream. In wrap mode, one chosen side (source or destination) returns to a programmed jump address each time a programmed wrap length has been moved on that side, while the other side keeps advancing. The slow-down option puts a programmable number of idle cycles between beats. A run can end in several ways: by finishing, by flush or stop (at the next beat boundary), by warm reset (any write still pending is dropped) or by hard reset (at once). Only a run that finishes sets the completion flag. The flag drives the interrupt output when the interrupt enable is set.

Top module: `cdma_channel`

## Requirements
- R1: Register map (byte offsets): 0x00 completion flag (bit 0), 0x04 interrupt enable (bit 0), 0x08 launch/busy (bit 0), 0x0C reset (bit 0 warm, bit 1 hard), 0x10 stop (bit 0), 0x14 flush (bit 0), 0x18 control, 0x1C source, 0x20 destination, 0x24 byte count, 0x28 wrap length, 0x2C jump address. Byte count and wrap length keep only bits [19:0]. Control keeps only bit 2 (slow enable), bits [14:5] (gap count), bit 15 (wrap enable) and bit 20 (wrap side, 0 = source, 1 = destination), and reads back 0 in every other bit. Any other offset reads 0.
- R2: Writing 1 to launch bit 0 while idle starts a run. That bit reads 1 until the run ends, then 0. A launch write during a run has no effect.
- R3: A run moves ceil(count/4) words. Read k uses source+4k and write k uses destination+4k (addresses with bits [1:0] forced to 0). Each write carries the data returned by its read. Each port holds its address and data stable while valid is high and ready is low.
- R4: A run that finishes sets the completion flag. Writing 0 to flag bit 0 clears it and writing 1 leaves it unchanged. If a clear and a completion fall in the same cycle, the flag ends up set.
- R5: The interrupt output is high exactly when the completion flag and the interrupt enable are both 1.
- R6: With slow enable set and gap count G greater than 0, the next read request appears G+1 cycles after the previous write handshake. Without the option it appears in the very next cycle.
- R7: With wrap enable set, the wrap side's address reloads from the jump address after each ceil(wraplen/4) words on that side. The other side stays linear. A wrap length of 0 disables the reload.
- R8: Flush held at 1, or a write of 1 to stop bit 0, ends the run after the current beat's write, without setting the flag. Launch writes are ignored while flush is 1. The stop bit clears itself once the engine is idle.
- R9: Writing 1 to warm reset bit 0 ends the run: a read already accepted is waited for, but its write is not issued. The flag is not set, and the bit clears itself once the engine is idle.
- R10: While hard reset bit 1 is 1, the engine is idle in the next cycle with both valid outputs low, the busy bit reads 0 and launch writes are ignored. Hard reset reads back as bit 1.
- R11: A launch with a byte count of 0 issues no read and sets the completion flag at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read word address |
| rd_resp_valid | input | 1 | Read data returned |
| rd_resp_data | input | DW | Returned read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Write word address |
| wr_data | output | DW | Write data |
| irq | output | 1 | Completion interrupt |

## Verification
Software clearing the completion flag and the engine finishing its last beat can land on the same clock edge. The bench stalls the last write with ready low. At one falling edge it then drives the flag-clear register write and raises write ready together, so both happen at the next rising edge. The flag must read back as 1 afterwards, which shows that the completion took priority over the clear.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam logic [7:0] OFS_FLAG  = 8'h00;
    localparam logic [7:0] OFS_INTEN = 8'h04;
    localparam logic [7:0] OFS_START = 8'h08;
    localparam logic [7:0] OFS_RESET = 8'h0C;
    localparam logic [7:0] OFS_STOP  = 8'h10;
    localparam logic [7:0] OFS_FLUSH = 8'h14;
    localparam logic [7:0] OFS_CTRL  = 8'h18;
    localparam logic [7:0] OFS_SRC   = 8'h1C;
    localparam logic [7:0] OFS_DST   = 8'h20;
    localparam logic [7:0] OFS_LEN1  = 8'h24;
    localparam logic [7:0] OFS_LEN2  = 8'h28;
    localparam logic [7:0] OFS_JUMP  = 8'h2C;

    localparam int CTRL_SLOW_BIT = 2;
    localparam int CTRL_GAP_LSB  = 5;
    localparam int CTRL_WRAP_BIT = 15;
    localparam int CTRL_SIDE_BIT = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RWAIT,
        ST_WR,
        ST_GAP
    } eng_state_t;

endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
    import cdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 20,
    parameter int GAP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             busy,
    input  logic             done_pulse,
    output logic             start_pulse,
    output logic [AW-1:0]    src,
    output logic [AW-1:0]    dst,
    output logic [AW-1:0]    jump,
    output logic [LEN_W-1:0] len1,
    output logic [LEN_W-1:0] len2,
    output logic             slow_en,
    output logic [GAP_W-1:0] gap,
    output logic             wrap_en,
    output logic             wrap_dst,
    output logic             flag,
    output logic             int_en,
    output logic             flush,
    output logic             stop,
    output logic             warm,
    output logic             hard
);

    typedef struct packed {
        logic             flag;
        logic             int_en;
        logic             warm;
        logic             hard;
        logic             stop;
        logic             flush;
        logic             slow_en;
        logic [GAP_W-1:0] gap;
        logic             wrap_en;
        logic             wrap_dst;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [LEN_W-1:0] len1;
        logic [LEN_W-1:0] len2;
        logic [AW-1:0]    jump;
    } regs_t;

    regs_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (!busy) begin
            reg_d.warm = 1'b0;
            reg_d.stop = 1'b0;
        end
        if (cfg_we) begin
            case (cfg_addr)
                OFS_FLAG:  if (!cfg_wdata[0]) reg_d.flag = 1'b0;
                OFS_INTEN: reg_d.int_en = cfg_wdata[0];
                OFS_RESET: begin
                    if (cfg_wdata[0]) reg_d.warm = 1'b1;
                    reg_d.hard = cfg_wdata[1];
                end
                OFS_STOP:  if (cfg_wdata[0]) reg_d.stop = 1'b1;
                OFS_FLUSH: reg_d.flush = cfg_wdata[0];
                OFS_CTRL: begin
                    reg_d.slow_en  = cfg_wdata[CTRL_SLOW_BIT];
                    reg_d.gap      = cfg_wdata[CTRL_GAP_LSB +: GAP_W];
                    reg_d.wrap_en  = cfg_wdata[CTRL_WRAP_BIT];
                    reg_d.wrap_dst = cfg_wdata[CTRL_SIDE_BIT];
                end
                OFS_SRC:   reg_d.src  = cfg_wdata[AW-1:0];
                OFS_DST:   reg_d.dst  = cfg_wdata[AW-1:0];
                OFS_LEN1:  reg_d.len1 = cfg_wdata[LEN_W-1:0];
                OFS_LEN2:  reg_d.len2 = cfg_wdata[LEN_W-1:0];
                OFS_JUMP:  reg_d.jump = cfg_wdata[AW-1:0];
                default: ;
            endcase
        end
        if (done_pulse) reg_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign start_pulse = cfg_we && (cfg_addr == OFS_START) && cfg_wdata[0];

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            OFS_FLAG:  cfg_rdata[0] = reg_q.flag;
            OFS_INTEN: cfg_rdata[0] = reg_q.int_en;
            OFS_START: cfg_rdata[0] = busy;
            OFS_RESET: cfg_rdata[1:0] = {reg_q.hard, reg_q.warm};
            OFS_STOP:  cfg_rdata[0] = reg_q.stop;
            OFS_FLUSH: cfg_rdata[0] = reg_q.flush;
            OFS_CTRL: begin
                cfg_rdata[CTRL_SLOW_BIT]          = reg_q.slow_en;
                cfg_rdata[CTRL_GAP_LSB +: GAP_W]  = reg_q.gap;
                cfg_rdata[CTRL_WRAP_BIT]          = reg_q.wrap_en;
                cfg_rdata[CTRL_SIDE_BIT]          = reg_q.wrap_dst;
            end
            OFS_SRC:   cfg_rdata[AW-1:0]    = reg_q.src;
            OFS_DST:   cfg_rdata[AW-1:0]    = reg_q.dst;
            OFS_LEN1:  cfg_rdata[LEN_W-1:0] = reg_q.len1;
            OFS_LEN2:  cfg_rdata[LEN_W-1:0] = reg_q.len2;
            OFS_JUMP:  cfg_rdata[AW-1:0]    = reg_q.jump;
            default: ;
        endcase
    end

    assign src      = reg_q.src;
    assign dst      = reg_q.dst;
    assign jump     = reg_q.jump;
    assign len1     = reg_q.len1;
    assign len2     = reg_q.len2;
    assign slow_en  = reg_q.slow_en;
    assign gap      = reg_q.gap;
    assign wrap_en  = reg_q.wrap_en;
    assign wrap_dst = reg_q.wrap_dst;
    assign flag     = reg_q.flag;
    assign int_en   = reg_q.int_en;
    assign flush    = reg_q.flush;
    assign stop     = reg_q.stop;
    assign warm     = reg_q.warm;
    assign hard     = reg_q.hard;

endmodule

// File: rtl/cdma_addr_gen.sv
module cdma_addr_gen #(
    parameter int AW    = 32,
    parameter int CNT_W = 19,
    parameter int BPW   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    jump,
    input  logic             wrap_on,
    input  logic [CNT_W-1:0] wrap_words,
    output logic [AW-1:0]    addr
);

    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BPW - 1);

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] cnt;
    } ag_t;

    ag_t ag_d, ag_q;

    always_comb begin
        ag_d = ag_q;
        if (load) begin
            ag_d.addr = base & ALIGN_MASK;
            ag_d.cnt  = '0;
        end else if (step) begin
            if (wrap_on && (wrap_words != '0) &&
                ((ag_q.cnt + CNT_W'(1)) == wrap_words)) begin
                ag_d.addr = jump & ALIGN_MASK;
                ag_d.cnt  = '0;
            end else begin
                ag_d.addr = ag_q.addr + AW'(BPW);
                ag_d.cnt  = ag_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ag_q <= '0;
        else        ag_q <= ag_d;
    end

    assign addr = ag_q.addr;

endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
    import cdma_pkg::*;
#(
    parameter int LEN_W = 20,
    parameter int GAP_W = 10,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_pulse,
    input  logic [LEN_W-1:0] len1,
    input  logic             slow_en,
    input  logic [GAP_W-1:0] gap,
    input  logic             halt,
    input  logic             warm,
    input  logic             hard,
    input  logic             rd_ready,
    input  logic             rd_resp_valid,
    input  logic [DW-1:0]    rd_resp_data,
    input  logic             wr_ready,
    output logic             active,
    output logic             busy,
    output logic             done_pulse,
    output logic             load,
    output logic             step,
    output logic             rd_valid,
    output logic             wr_valid,
    output logic [DW-1:0]    wr_data
);

    localparam int BPW     = DW / 8;
    localparam int ALIGN_B = $clog2(BPW);
    localparam int CNT_W   = LEN_W - ALIGN_B + 1;

    typedef struct packed {
        eng_state_t       state;
        logic [CNT_W-1:0] words;
        logic [GAP_W-1:0] gap_cnt;
        logic [DW-1:0]    data;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [LEN_W:0]   len_up;
    logic [CNT_W-1:0] words_req;

    assign len_up    = {1'b0, len1} + (LEN_W + 1)'(BPW - 1);
    assign words_req = len_up[LEN_W:ALIGN_B];

    always_comb begin
        eng_d      = eng_q;
        done_pulse = 1'b0;
        load       = 1'b0;
        step       = 1'b0;
        case (eng_q.state)
            ST_IDLE: begin
                if (start_pulse && !hard && !halt) begin
                    if (words_req == '0) begin
                        done_pulse = 1'b1;
                    end else begin
                        load        = 1'b1;
                        eng_d.words = words_req;
                        eng_d.state = ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (halt || warm)  eng_d.state = ST_IDLE;
                else if (rd_ready) eng_d.state = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (rd_resp_valid) begin
                    eng_d.data  = rd_resp_data;
                    eng_d.state = warm ? ST_IDLE : ST_WR;
                end
            end
            ST_WR: begin
                if (wr_ready) begin
                    step        = 1'b1;
                    eng_d.words = eng_q.words - CNT_W'(1);
                    if (eng_q.words == CNT_W'(1)) begin
                        done_pulse  = 1'b1;
                        eng_d.state = ST_IDLE;
                    end else if (halt || warm) begin
                        eng_d.state = ST_IDLE;
                    end else if (slow_en && (gap != '0)) begin
                        eng_d.gap_cnt = gap;
                        eng_d.state   = ST_GAP;
                    end else begin
                        eng_d.state = ST_RD;
                    end
                end
            end
            ST_GAP: begin
                if (halt || warm)                    eng_d.state = ST_IDLE;
                else if (eng_q.gap_cnt <= GAP_W'(1)) eng_d.state = ST_RD;
                else eng_d.gap_cnt = eng_q.gap_cnt - GAP_W'(1);
            end
            default: eng_d.state = ST_IDLE;
        endcase
        if (hard) begin
            eng_d.state = ST_IDLE;
            done_pulse  = 1'b0;
            load        = 1'b0;
            step        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{state: ST_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    assign active   = (eng_q.state != ST_IDLE);
    assign busy     = active && !hard;
    assign rd_valid = (eng_q.state == ST_RD) && !halt && !warm && !hard;
    assign wr_valid = (eng_q.state == ST_WR) && !hard;
    assign wr_data  = eng_q.data;

endmodule

// File: rtl/cdma_channel.sv
module cdma_channel
    import cdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LEN_W = 20,
    parameter int GAP_W = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_resp_valid,
    input  logic [DW-1:0] rd_resp_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          irq
);

    localparam int BPW     = DW / 8;
    localparam int ALIGN_B = $clog2(BPW);
    localparam int CNT_W   = LEN_W - ALIGN_B + 1;

    logic             start_pulse, done_pulse, busy, active, load, step;
    logic [AW-1:0]    src, dst, jump;
    logic [LEN_W-1:0] len1, len2;
    logic             slow_en, wrap_en, wrap_dst;
    logic [GAP_W-1:0] gap;
    logic             flag, int_en, flush, stop, warm, hard, halt;
    logic [LEN_W:0]   len2_up;
    logic [CNT_W-1:0] wrap_words;
    logic [AW-1:0]    side_base [2];
    logic [AW-1:0]    side_addr [2];

    cdma_regs #(.AW(AW), .LEN_W(LEN_W), .GAP_W(GAP_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .busy(busy), .done_pulse(done_pulse), .start_pulse(start_pulse),
        .src(src), .dst(dst), .jump(jump), .len1(len1), .len2(len2),
        .slow_en(slow_en), .gap(gap), .wrap_en(wrap_en), .wrap_dst(wrap_dst),
        .flag(flag), .int_en(int_en), .flush(flush), .stop(stop),
        .warm(warm), .hard(hard)
    );

    assign halt = flush || stop;

    cdma_engine #(.LEN_W(LEN_W), .GAP_W(GAP_W), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start_pulse(start_pulse), .len1(len1), .slow_en(slow_en), .gap(gap),
        .halt(halt), .warm(warm), .hard(hard),
        .rd_ready(rd_ready), .rd_resp_valid(rd_resp_valid),
        .rd_resp_data(rd_resp_data), .wr_ready(wr_ready),
        .active(active), .busy(busy), .done_pulse(done_pulse),
        .load(load), .step(step),
        .rd_valid(rd_valid), .wr_valid(wr_valid), .wr_data(wr_data)
    );

    assign len2_up    = {1'b0, len2} + (LEN_W + 1)'(BPW - 1);
    assign wrap_words = len2_up[LEN_W:ALIGN_B];

    assign side_base[0] = src;
    assign side_base[1] = dst;

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic wrap_here;
        assign wrap_here = wrap_en && (wrap_dst == (s == 1));
        cdma_addr_gen #(.AW(AW), .CNT_W(CNT_W), .BPW(BPW)) u_ag (
            .clk(clk), .rst_n(rst_n),
            .load(load), .step(step),
            .base(side_base[s]), .jump(jump),
            .wrap_on(wrap_here), .wrap_words(wrap_words),
            .addr(side_addr[s])
        );
    end

    assign rd_addr = side_addr[0];
    assign wr_addr = side_addr[1];
    assign irq     = flag && int_en;

endmodule

// File: rtl/cdma_channel_chk.sv
module cdma_channel_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [AW-1:0] rd_addr,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          active,
    input logic          start_pulse,
    input logic          done_pulse,
    input logic          flag,
    input logic          halt,
    input logic          warm,
    input logic          hard
);

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=>
            ((rd_valid && $stable(rd_addr)) || halt || warm || hard));

    assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=>
            ((wr_valid && $stable(wr_addr) && $stable(wr_data)) || hard));

    assert_launch_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start_pulse));

    assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !active);

    assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(done_pulse));

    assert_hard_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hard |=> !active);

endmodule

bind cdma_channel cdma_channel_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .active(active), .start_pulse(start_pulse),
    .done_pulse(done_pulse), .flag(flag), .halt(halt), .warm(warm),
    .hard(hard)
);

// File: tb/cdma_channel_test.sv
module cdma_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rd_valid, wr_valid, irq;
    logic        rd_ready = 1'b1;
    logic        wr_ready = 1'b1;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        rd_resp_valid = 1'b0;
    logic [31:0] rd_resp_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [31:0] rlog [256];
    int          rcyc [256];
    logic [31:0] wlog_a [256];
    logic [31:0] wlog_d [256];
    int          wcyc [256];
    int          nr = 0;
    int          nw = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic        resp_hold = 1'b0;

    always #5 clk = ~clk;

    cdma_channel uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq(irq)
    );

    function automatic logic [31:0] mem(input logic [31:0] a);
        return a ^ 32'hC3C3_0000;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // memory responder: one-cycle read latency, logs every handshake
    always @(negedge clk) begin
        if (pend && !resp_hold) begin
            rd_resp_valid = 1'b1;
            rd_resp_data  = mem(pend_addr);
            pend          = 1'b0;
        end else begin
            rd_resp_valid = 1'b0;
        end
        if (rd_valid && rd_ready) begin
            pend      = 1'b1;
            pend_addr = rd_addr;
            if (nr < 256) begin rlog[nr] = rd_addr; rcyc[nr] = cyc; end
            nr = nr + 1;
        end
        if (wr_valid && wr_ready) begin
            if (nw < 256) begin
                wlog_a[nw] = wr_addr; wlog_d[nw] = wr_data; wcyc[nw] = cyc;
            end
            nw = nw + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd_reg(8'h08, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    task automatic clear_logs();
        nr = 0; nw = 0;
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] dd,
                         input logic [31:0] len, input logic [31:0] ctrl);
        wr_reg(8'h1C, s);
        wr_reg(8'h20, dd);
        wr_reg(8'h24, len);
        wr_reg(8'h18, ctrl);
        wr_reg(8'h00, 32'h0);
        clear_logs();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(8'h08, v); chk("R2 reset busy", v, 32'h0);
        rd_reg(8'h00, v); chk("R4 reset flag", v, 32'h0);
        chk("R5 reset irq", {31'h0, irq}, 32'h0);
        chk("R3 reset valids", {30'h0, rd_valid, wr_valid}, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr_reg(8'h24, 32'hFFFF_FFFF); rd_reg(8'h24, v);
        chk("R1 len1 mask", v, 32'h000F_FFFF);
        wr_reg(8'h28, 32'hABC1_2345); rd_reg(8'h28, v);
        chk("R1 len2 mask", v, 32'h0001_2345);
        wr_reg(8'h18, 32'hFFFF_FFFF); rd_reg(8'h18, v);
        chk("R1 ctrl fields", v, 32'h0010_FFE4);
        wr_reg(8'h2C, 32'h0000_3002); rd_reg(8'h2C, v);
        chk("R1 jump", v, 32'h0000_3002);
        rd_reg(8'h40, v); chk("R1 unmapped 0x40", v, 32'h0);
        rd_reg(8'h3C, v); chk("R1 unmapped 0x3C", v, 32'h0);
        wr_reg(8'h18, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        setup(32'h1000, 32'h2000, 32'd10, 32'h0);
        wr_reg(8'h04, 32'h0);
        wr_reg(8'h08, 32'h1);
        rd_reg(8'h08, v); chk("R2 busy during run", v, 32'h1);
        wr_reg(8'h08, 32'h1);
        wait_idle();
        rd_reg(8'h08, v); chk("R2 busy cleared", v, 32'h0);
        chk("R3 read count", nr, 3);
        chk("R3 write count", nw, 3);
        for (int k = 0; k < 3; k++) begin
            chk("R3 read addr", rlog[k], 32'h1000 + 32'(4 * k));
            chk("R3 write addr", wlog_a[k], 32'h2000 + 32'(4 * k));
            chk("R3 write data", wlog_d[k], mem(32'h1000 + 32'(4 * k)));
        end
        chk("R6 no gap", rcyc[1] - wcyc[0], 1);
        rd_reg(8'h00, v); chk("R4 flag set", v, 32'h1);
        chk("R5 irq off while disabled", {31'h0, irq}, 32'h0);
        wr_reg(8'h04, 32'h1);
        chk("R5 irq on", {31'h0, irq}, 32'h1);
        wr_reg(8'h00, 32'h1); rd_reg(8'h00, v);
        chk("R4 write 1 keeps flag", v, 32'h1);
        wr_reg(8'h00, 32'h0); rd_reg(8'h00, v);
        chk("R4 write 0 clears", v, 32'h0);
        chk("R5 irq off after clear", {31'h0, irq}, 32'h0);
        wr_reg(8'h04, 32'h0);
    endtask

    task automatic t_gap();
        setup(32'h1000, 32'h2000, 32'd12, (32'd3 << 5) | 32'h4);
        wr_reg(8'h08, 32'h1);
        wait_idle();
        chk("R6 gap words", nw, 3);
        chk("R6 gap beat1", rcyc[1] - wcyc[0], 4);
        chk("R6 gap beat2", rcyc[2] - wcyc[1], 4);
    endtask

    task automatic t_wrap();
        logic [31:0] exp_r [5];
        logic [31:0] exp_w [5];
        // source side, wrap length 8 bytes
        setup(32'h1000, 32'h2000, 32'd20, 32'h0000_8000);
        wr_reg(8'h28, 32'd8);
        wr_reg(8'h2C, 32'h3000);
        wr_reg(8'h08, 32'h1);
        wait_idle();
        exp_r = '{32'h1000, 32'h1004, 32'h3000, 32'h3004, 32'h3000};
        chk("R7 src wrap count", nw, 5);
        for (int k = 0; k < 5; k++) begin
            chk("R7 src wrap read", rlog[k], exp_r[k]);
            chk("R7 src side dst linear", wlog_a[k], 32'h2000 + 32'(4 * k));
            chk("R7 src wrap data", wlog_d[k], mem(exp_r[k]));
        end
        // destination side, wrap length 6 bytes rounds to 2 words
        setup(32'h1000, 32'h2000, 32'd20, 32'h0010_8000);
        wr_reg(8'h28, 32'd6);
        wr_reg(8'h08, 32'h1);
        wait_idle();
        exp_w = '{32'h2000, 32'h2004, 32'h3000, 32'h3004, 32'h3000};
        for (int k = 0; k < 5; k++) begin
            chk("R7 dst side src linear", rlog[k], 32'h1000 + 32'(4 * k));
            chk("R7 dst wrap write", wlog_a[k], exp_w[k]);
        end
        wr_reg(8'h28, 32'd0);
    endtask

    task automatic t_flush_stop();
        logic [31:0] v;
        setup(32'h1000, 32'h2000, 32'd400, 32'h0);
        wr_reg(8'h08, 32'h1);
        repeat (10) @(negedge clk);
        wr_reg(8'h14, 32'h1);
        wait_idle();
        rd_reg(8'h08, v); chk("R8 flush idle", v, 32'h0);
        chk("R8 flush cut short", {31'h0, (nw > 0 && nw < 100)}, 32'h1);
        chk("R8 flush beat whole", nw, nr);
        rd_reg(8'h00, v); chk("R8 flush no flag", v, 32'h0);
        wr_reg(8'h08, 32'h1);
        rd_reg(8'h08, v); chk("R8 launch ignored in flush", v, 32'h0);
        wr_reg(8'h14, 32'h0);
        clear_logs();
        wr_reg(8'h08, 32'h1);
        repeat (10) @(negedge clk);
        wr_reg(8'h10, 32'h1);
        wait_idle();
        chk("R8 stop cut short", {31'h0, (nw > 0 && nw < 100)}, 32'h1);
        chk("R8 stop beat whole", nw, nr);
        rd_reg(8'h10, v); chk("R8 stop self clears", v, 32'h0);
        rd_reg(8'h00, v); chk("R8 stop no flag", v, 32'h0);
    endtask

    task automatic t_warm();
        logic [31:0] v;
        setup(32'h1000, 32'h2000, 32'd40, 32'h0);
        resp_hold = 1'b1;
        wr_reg(8'h08, 32'h1);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (nr >= 1) break;
        end
        wr_reg(8'h0C, 32'h1);
        repeat (3) @(negedge clk);
        resp_hold = 1'b0;
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R9 pending write dropped", nw, 0);
        chk("R9 one read issued", nr, 1);
        rd_reg(8'h08, v); chk("R9 busy cleared", v, 32'h0);
        rd_reg(8'h00, v); chk("R9 no flag", v, 32'h0);
        rd_reg(8'h0C, v); chk("R9 warm self clears", v, 32'h0);
        // warm while the read request is still waiting for ready
        clear_logs();
        rd_ready = 1'b0;
        wr_reg(8'h08, 32'h1);
        wr_reg(8'h0C, 32'h1);
        rd_ready = 1'b1;
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R9 unaccepted read abandoned", nr, 0);
    endtask

    task automatic t_hard();
        logic [31:0] v;
        setup(32'h1000, 32'h2000, 32'd8, 32'h0);
        wr_ready = 1'b0;
        wr_reg(8'h08, 32'h1);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (wr_valid) break;
        end
        wr_reg(8'h0C, 32'h2);
        chk("R10 write valid dropped", {31'h0, wr_valid}, 32'h0);
        rd_reg(8'h08, v); chk("R10 busy reads 0", v, 32'h0);
        rd_reg(8'h0C, v); chk("R10 hard reads back", v, 32'h2);
        wr_reg(8'h08, 32'h1);
        rd_reg(8'h08, v); chk("R10 launch ignored", v, 32'h0);
        wr_reg(8'h0C, 32'h0);
        wr_ready = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 nothing resumes", nw, 0);
        rd_reg(8'h08, v); chk("R10 idle after release", v, 32'h0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        setup(32'h1000, 32'h2000, 32'd0, 32'h0);
        wr_reg(8'h08, 32'h1);
        rd_reg(8'h00, v); chk("R11 zero length flag", v, 32'h1);
        repeat (3) @(negedge clk);
        chk("R11 zero length no read", nr, 0);
        wr_reg(8'h00, 32'h0);
    endtask

    task automatic t_clear_vs_done();
        logic [31:0] v;
        setup(32'h1000, 32'h2000, 32'd4, 32'h0);
        wr_ready = 1'b0;
        wr_reg(8'h08, 32'h1);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (wr_valid) break;
        end
        cfg_we = 1'b1; cfg_addr = 8'h00; cfg_wdata = 32'h0;
        wr_ready = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        rd_reg(8'h00, v); chk("R4 completion beats clear", v, 32'h1);
        rd_reg(8'h08, v); chk("R2 idle after last beat", v, 32'h0);
        wr_reg(8'h00, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_basic();
        t_gap();
        t_wrap();
        t_flush_stop();
        t_warm();
        t_hard();
        t_zero();
        t_clear_vs_done();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule